// File: doc/BRIEF.md
# Dual-Width Parallel-to-Serial Transmitter

This block turns a parallel word into a serial bit stream, one bit for each bit-clock cycle, least significant active bit first. A static width-select input picks the word size. When it is low, the word is 20 bits wide and uses the whole bus. When it is high, the word is 10 bits wide and is carried on the upper half of the bus. A word-rate clock, given as a true and complement pair, tells the upstream logic when to present the next word. Each word is latched on a rising edge of the reference clock and goes out back to back after the word in flight, with no idle bits between words.

The serial stream leaves on two differential pairs with identical content: a primary pair and a loopback copy. Each pair has its own enable, and a disabled pair rests at a fixed idle level. A rising edge on the width-select line restarts the word sequencing. A test input lets the reference clock stand in for the bit clock, so the block can be stepped without a bit-rate clock source. The bit clock is an ordinary clock input. Clock multiplication and output drivers are outside this block.

Top module: `sertx_top`

## Requirements
- R1: With `half_width` low, each word sends `data_in[0]` first and then bits 1 through 19 in ascending order, one bit per bit-clock cycle.
- R2: With `half_width` high, each word sends `data_in[10]` first and then bits 11 through 19 in ascending order. Bits 0 to 9 have no effect on the output.
- R3: `data_in` is latched on a rising edge of `clk_ref`. A word latched while word k is being sent goes out as word k+1, with no gap after the last bit of word k.
- R4: `wclk_p` has a period of exactly the active width in bit-clock cycles: 20 in full mode and 10 in half mode. It is high for the first half of each word and rises in the cycle that carries the first bit. `wclk_n` is always its complement.
- R5: A rising edge on `half_width` restarts sequencing. `wclk_p` is low after the next bit-clock edge and high after the edge that follows, and that second edge starts a new 10-bit word.
- R6: While `oe_main` is high, `ser_main_p` carries the serial bit and `ser_main_n` its complement. While `oe_main` is low, the pair rests at `ser_main_p`=0 and `ser_main_n`=1.
- R7: The loopback pair `ser_loop_p`/`ser_loop_n` carries the same bits as the primary pair under its own enable `oe_loop`, and rests at 0/1 when that enable is low. Its content does not depend on `oe_main`.
- R8: While `test_mode` is high, the block is clocked by `clk_ref` in place of `clk_bit`, so the word period counts `clk_ref` cycles.
- R9: While the synchronous reset `rst` is high, `wclk_p` is 0 and an enabled serial pair outputs 0/1. The first bit-clock edge after `rst` falls starts a word, and `wclk_p` goes high on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock |
| clk_ref | input | 1 | Reference clock. Latches the parallel word and replaces the bit clock in test mode |
| test_mode | input | 1 | High: the block runs from `clk_ref` |
| rst | input | 1 | Synchronous active-high reset |
| half_width | input | 1 | Low: 20-bit words. High: 10-bit words on the upper bus half. A rising edge restarts sequencing |
| data_in | input | 20 | Parallel word |
| oe_main | input | 1 | Enable for the primary serial pair |
| oe_loop | input | 1 | Enable for the loopback serial pair |
| wclk_p | output | 1 | Word-rate clock, true |
| wclk_n | output | 1 | Word-rate clock, complement |
| ser_main_p | output | 1 | Primary serial output, true |
| ser_main_n | output | 1 | Primary serial output, complement |
| ser_loop_p | output | 1 | Loopback serial output, true |
| ser_loop_n | output | 1 | Loopback serial output, complement |

## Verification
The scoreboard pushes each word just after the `clk_ref` edge that follows a word-clock rise. That word goes out as the second word to start after the push, so the monitor discards exactly two words at the start of every burst and then compares each word in order. All outputs change on rising clock edges and are sampled on the following falling edge. The restart after a width rise is therefore checked one sample later (word clock low) and two samples later (word clock high). The word-clock period and duty cycle are counted in samples of whichever clock drives the block at the time, either the bit clock or, in test mode, the reference clock.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned FULL_W_DEF = 20;

    typedef enum logic {
        MODE_FULL = 1'b0,
        MODE_HALF = 1'b1
    } width_mode_e;

    typedef struct packed {
        logic p;
        logic n;
    } diff_pair_t;

    // Number of bits in one word for the selected mode.
    function automatic int unsigned active_width(width_mode_e mode, int unsigned full_w);
        return (mode == MODE_HALF) ? full_w / 2 : full_w;
    endfunction

endpackage

// File: rtl/sertx_capture.sv
module sertx_capture
    import sertx_pkg::*;
#(
    parameter int unsigned FULL_W = FULL_W_DEF
) (
    input  logic              clk_ref,
    input  logic              rst,
    input  logic [FULL_W-1:0] data_in,
    output logic [FULL_W-1:0] hold_q
);

    // The parallel word is latched in the reference-clock domain.
    always_ff @(posedge clk_ref) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= data_in;
        end
    end

endmodule

// File: rtl/sertx_sequencer.sv
module sertx_sequencer
    import sertx_pkg::*;
#(
    parameter int unsigned FULL_W = FULL_W_DEF,
    localparam int unsigned CW    = $clog2(FULL_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  width_mode_e   mode,
    output logic [CW-1:0] cnt_q,
    output logic          load,
    output logic          rst_int,
    output logic          wclk
);

    width_mode_e   mode_q;
    logic [CW-1:0] last_idx;
    logic [CW-1:0] half_len;

    assign last_idx = CW'(active_width(mode, FULL_W) - 1);
    assign half_len = CW'(active_width(mode, FULL_W) / 2);

    // Previous width select, used to find a rising edge.
    always_ff @(posedge clk) begin
        mode_q <= mode;
    end

    assign rst_int = rst | ((mode == MODE_HALF) && (mode_q == MODE_FULL));

    // The counter wraps on >= so that a word already longer than the new
    // width still ends at once.
    assign load = (cnt_q >= last_idx);

    always_ff @(posedge clk) begin
        if (rst_int) begin
            cnt_q <= last_idx;
        end else if (load) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wclk = (cnt_q < half_len);

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int unsigned FULL_W = FULL_W_DEF,
    localparam int unsigned HALF_W = FULL_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  width_mode_e       mode,
    input  logic [FULL_W-1:0] hold,
    output logic              ser_bit
);

    logic [FULL_W-1:0] sreg_q;
    logic [FULL_W-1:0] load_word;

    // In half mode the upper half of the bus drops to the bottom of the register.
    assign load_word = (mode == MODE_HALF) ? FULL_W'(hold[FULL_W-1:HALF_W]) : hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= load_word;
        end else begin
            sreg_q <= sreg_q >> 1;
        end
    end

    assign ser_bit = sreg_q[0];

endmodule

// File: rtl/sertx_lineout.sv
module sertx_lineout
    import sertx_pkg::*;
(
    input  logic       en,
    input  logic       bit_in,
    output diff_pair_t pair
);

    // A disabled pair rests at true=0, complement=1.
    assign pair.p = en & bit_in;
    assign pair.n = ~(en & bit_in);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int unsigned FULL_W = FULL_W_DEF
) (
    input  logic              clk_bit,
    input  logic              clk_ref,
    input  logic              test_mode,
    input  logic              rst,
    input  logic              half_width,
    input  logic [FULL_W-1:0] data_in,
    input  logic              oe_main,
    input  logic              oe_loop,
    output logic              wclk_p,
    output logic              wclk_n,
    output logic              ser_main_p,
    output logic              ser_main_n,
    output logic              ser_loop_p,
    output logic              ser_loop_n
);

    localparam int unsigned CW        = $clog2(FULL_W);
    localparam int unsigned NUM_LANES = 2;

    logic              clk_int;
    width_mode_e       mode;
    logic [FULL_W-1:0] hold_q;
    logic [CW-1:0]     cnt_q;
    logic              load;
    logic              rst_int;
    logic              wclk;
    logic              ser_bit;

    logic [NUM_LANES-1:0] lane_en;
    diff_pair_t           lane_pair [NUM_LANES];

    // In test mode the reference clock takes the place of the bit clock.
    assign clk_int = test_mode ? clk_ref : clk_bit;
    assign mode    = width_mode_e'(half_width);

    sertx_capture #(.FULL_W(FULL_W)) u_capture (
        .clk_ref (clk_ref),
        .rst     (rst),
        .data_in (data_in),
        .hold_q  (hold_q)
    );

    sertx_sequencer #(.FULL_W(FULL_W)) u_seq (
        .clk     (clk_int),
        .rst     (rst),
        .mode    (mode),
        .cnt_q   (cnt_q),
        .load    (load),
        .rst_int (rst_int),
        .wclk    (wclk)
    );

    sertx_shifter #(.FULL_W(FULL_W)) u_shift (
        .clk     (clk_int),
        .rst     (rst),
        .load    (load),
        .mode    (mode),
        .hold    (hold_q),
        .ser_bit (ser_bit)
    );

    assign lane_en = {oe_loop, oe_main};

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        sertx_lineout u_line (
            .en     (lane_en[g]),
            .bit_in (ser_bit),
            .pair   (lane_pair[g])
        );
    end

    assign wclk_p     = wclk;
    assign wclk_n     = ~wclk;
    assign ser_main_p = lane_pair[0].p;
    assign ser_main_n = lane_pair[0].n;
    assign ser_loop_p = lane_pair[1].p;
    assign ser_loop_n = lane_pair[1].n;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk
    import sertx_pkg::*;
#(
    parameter int unsigned FULL_W = FULL_W_DEF,
    localparam int unsigned CW     = $clog2(FULL_W),
    localparam int unsigned HALF_W = FULL_W / 2
) (
    input logic          clk,
    input logic          rst,
    input logic          rst_int,
    input logic          half_sel,
    input logic [CW-1:0] cnt,
    input logic          load,
    input logic          hold_lo,
    input logic          hold_mid,
    input logic          ser_bit,
    input logic          wclk_p,
    input logic          oe_main,
    input logic          oe_loop,
    input logic          ser_main_p,
    input logic          ser_main_n,
    input logic          ser_loop_p
);

    // R1
    full_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !half_sel) |=> (ser_bit == $past(hold_lo)));

    // R2
    half_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (load && half_sel) |=> (ser_bit == $past(hold_mid)));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !rst_int) |=> (cnt == $past(cnt) + CW'(1)));

    // R4
    wclk_start_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !rst_int) |=> wclk_p);

    // R5
    width_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (half_sel && !$past(half_sel)) |=> (cnt == CW'(HALF_W - 1)));

    // R6
    main_pair_chk: assert property (@(posedge clk) disable iff (rst)
        oe_main |-> (ser_main_p != ser_main_n));

    // R7
    lane_match_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_main && oe_loop) |-> (ser_main_p == ser_loop_p));

endmodule

bind sertx_top sertx_chk #(.FULL_W(FULL_W)) chk_i (
    .clk        (clk_int),
    .rst        (rst),
    .rst_int    (rst_int),
    .half_sel   (half_width),
    .cnt        (cnt_q),
    .load       (load),
    .hold_lo    (hold_q[0]),
    .hold_mid   (hold_q[FULL_W/2]),
    .ser_bit    (ser_bit),
    .wclk_p     (wclk_p),
    .oe_main    (oe_main),
    .oe_loop    (oe_loop),
    .ser_main_p (ser_main_p),
    .ser_main_n (ser_main_n),
    .ser_loop_p (ser_loop_p)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int REF_PERIOD = 14;
    localparam int FW         = 20;

    logic clk_bit = 1'b0;
    logic ref_free = 1'b0;
    logic ref_locked = 1'b0;
    logic clk_ref;
    logic test_mode, rst, half_width, oe_main, oe_loop;
    logic [FW-1:0] data_in;
    logic wclk_p, wclk_n, ser_main_p, ser_main_n, ser_loop_p, ser_loop_n;

    int checks = 0;
    int errors = 0;

    logic [FW-1:0] exp_q[$];
    int  skip_words = 0;
    bit  mon_loop = 1'b0;
    int  bitpos = 0;
    bit  collecting = 1'b0;
    bit  prev_w = 1'b0;
    bit  idle_ok = 1'b1;
    logic [FW-1:0] main_word = '0;
    logic [FW-1:0] loop_word = '0;

    always #(CLK_PERIOD/2) clk_bit = ~clk_bit;
    always #(REF_PERIOD/2) ref_free = ~ref_free;

    // The locked reference follows the word clock half a bit later.
    always @(negedge clk_bit) ref_locked <= wclk_p;
    assign clk_ref = test_mode ? ref_free : ref_locked;

    sertx_top dut_i (
        .clk_bit    (clk_bit),
        .clk_ref    (clk_ref),
        .test_mode  (test_mode),
        .rst        (rst),
        .half_width (half_width),
        .data_in    (data_in),
        .oe_main    (oe_main),
        .oe_loop    (oe_loop),
        .wclk_p     (wclk_p),
        .wclk_n     (wclk_n),
        .ser_main_p (ser_main_p),
        .ser_main_n (ser_main_n),
        .ser_loop_p (ser_loop_p),
        .ser_loop_n (ser_loop_n)
    );

    task automatic check(bit ok, string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic finish_word();
        logic [FW-1:0] exp_w;
        logic [FW-1:0] got;
        if (skip_words > 0) begin
            skip_words--;
        end else if (exp_q.size() > 0) begin
            exp_w = exp_q.pop_front();
            got   = mon_loop ? loop_word : main_word;
            if (half_width) begin
                check(got[9:0] == exp_w[19:10],
                      $sformatf("R2 R3 half word actual=%0h expected=%0h", got[9:0], exp_w[19:10]));
            end else begin
                check(got == exp_w,
                      $sformatf("R1 R3 full word actual=%0h expected=%0h", got, exp_w));
            end
            if (mon_loop) begin
                check(idle_ok, $sformatf("R6 disabled main pair actual=%0d expected=1", idle_ok));
            end else if (oe_loop) begin
                check(loop_word == main_word,
                      $sformatf("R7 loop copy actual=%0h expected=%0h", loop_word, main_word));
            end
        end
    endtask

    // Monitor: deserializes one word per word-clock period.
    always @(negedge clk_bit) begin
        if (!test_mode) begin
            if (wclk_p && !prev_w) begin
                bitpos     = 0;
                collecting = 1'b1;
                idle_ok    = 1'b1;
                main_word  = '0;
                loop_word  = '0;
            end
            if (collecting) begin
                main_word[bitpos] = ser_main_p;
                loop_word[bitpos] = ser_loop_p;
                if (ser_main_p || !ser_main_n) idle_ok = 1'b0;
                bitpos++;
                if (bitpos == (half_width ? FW/2 : FW)) begin
                    collecting = 1'b0;
                    finish_word();
                end
            end
            prev_w = wclk_p;
        end
    end

    // Driver: one word after each reference edge; the first two words out are stale.
    task automatic send_words(int n, logic [FW-1:0] first);
        @(posedge clk_ref);
        #1;
        skip_words = 2;
        for (int i = 0; i < n; i++) begin
            data_in = (i == 0) ? first : FW'($urandom);
            exp_q.push_back(data_in);
            @(posedge clk_ref);
            #1;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && exp_q.size() > 0; i++) @(negedge clk_bit);
        check(exp_q.size() == 0, $sformatf("R3 words left actual=%0d expected=0", exp_q.size()));
    endtask

    task automatic tick(bit use_ref);
        if (use_ref) @(negedge ref_free);
        else @(negedge clk_bit);
    endtask

    task automatic wait_rise(bit use_ref);
        bit pv;
        pv = wclk_p;
        for (int i = 0; i < 200; i++) begin
            tick(use_ref);
            if (wclk_p && !pv) break;
            pv = wclk_p;
        end
    endtask

    task automatic measure(int exp_hi, int exp_per, bit use_ref, string tag);
        bit pv;
        bit comp_ok;
        int hi;
        int per;
        wait_rise(use_ref);
        pv = 1'b1; hi = 1; per = 1; comp_ok = 1'b1;
        for (int i = 0; i < 200; i++) begin
            tick(use_ref);
            if (wclk_n == wclk_p) comp_ok = 1'b0;
            if (wclk_p && !pv) break;
            if (wclk_p) hi++;
            per++;
            pv = wclk_p;
        end
        check(per == exp_per, $sformatf("%s word clock period actual=%0d expected=%0d", tag, per, exp_per));
        check(hi == exp_hi, $sformatf("%s word clock high actual=%0d expected=%0d", tag, hi, exp_hi));
        check(comp_ok, $sformatf("R4 word clock complement actual=%0d expected=1", comp_ok));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_mode = 1'b0; rst = 1'b1; half_width = 1'b0;
        oe_main = 1'b1; oe_loop = 1'b1; data_in = '0;
        repeat (4) @(negedge clk_bit);
        // R9 reset state
        check(wclk_p == 1'b0 && wclk_n == 1'b1,
              $sformatf("R9 word clock in reset actual=%b%b expected=01", wclk_p, wclk_n));
        check(ser_main_p == 1'b0 && ser_main_n == 1'b1 && ser_loop_p == 1'b0,
              $sformatf("R9 serial in reset actual=%b%b%b expected=010", ser_main_p, ser_main_n, ser_loop_p));
        rst = 1'b0;
        @(negedge clk_bit);
        check(wclk_p == 1'b1, $sformatf("R9 first word start actual=%b expected=1", wclk_p));

        // R1 R3 R7: full words, both pairs enabled
        send_words(12, 20'h00001);
        drain();

        // R6 R7: primary disabled, data read from the loopback pair
        oe_main = 1'b0; mon_loop = 1'b1;
        @(negedge clk_bit);
        check(ser_main_p == 1'b0 && ser_main_n == 1'b1,
              $sformatf("R6 idle level actual=%b%b expected=01", ser_main_p, ser_main_n));
        send_words(6, 20'h80000);
        drain();
        oe_main = 1'b1; oe_loop = 1'b0; mon_loop = 1'b0;
        @(negedge clk_bit);
        check(ser_loop_p == 1'b0 && ser_loop_n == 1'b1,
              $sformatf("R7 loop idle level actual=%b%b expected=01", ser_loop_p, ser_loop_n));
        check(ser_main_n == ~ser_main_p,
              $sformatf("R6 enabled pair actual=%b%b expected complement", ser_main_p, ser_main_n));
        oe_loop = 1'b1;

        // R4 full-mode word clock
        measure(10, 20, 1'b0, "R4");

        // R5 rising width select two bits into a full word
        wait_rise(1'b0);
        @(negedge clk_bit);
        @(negedge clk_bit);
        half_width = 1'b1;
        @(negedge clk_bit);
        check(wclk_p == 1'b0, $sformatf("R5 after rise edge 1 actual=%b expected=0", wclk_p));
        @(negedge clk_bit);
        check(wclk_p == 1'b1, $sformatf("R5 after rise edge 2 actual=%b expected=1", wclk_p));
        measure(5, 10, 1'b0, "R4 R5");

        // R2: half words, low bits random
        send_words(12, 20'h00400);
        drain();

        // Back to full width under reset
        rst = 1'b1; half_width = 1'b0;
        repeat (3) @(negedge clk_bit);
        rst = 1'b0;
        @(negedge clk_bit);
        check(wclk_p == 1'b1, $sformatf("R9 restart actual=%b expected=1", wclk_p));
        send_words(4, 20'hABCDE);
        drain();

        // R8: reference clock drives the block
        rst = 1'b1; test_mode = 1'b1; half_width = 1'b1;
        repeat (3) @(negedge ref_free);
        rst = 1'b0;
        measure(5, 10, 1'b1, "R8 half");
        rst = 1'b1; half_width = 1'b0;
        repeat (3) @(negedge ref_free);
        rst = 1'b0;
        measure(10, 20, 1'b1, "R8 full");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule